// File: doc/BRIEF.md
# Carry-Less Polynomial Multiply-Accumulate Unit

This unit treats two 32-bit operands as polynomials with coefficients in GF(2) and multiplies them. Partial products are combined with exclusive-OR, so no carries propagate between bit positions. The result is a 64-bit product whose top bit is always zero. It is kept in a pair of 32-bit result registers: a high word and a low word.

A single strobe starts an operation. A mode input selects one of two modes. Plain multiply overwrites the result pair and raises a one-cycle request to clear an external extension register. Multiply-accumulate XORs the new product into the existing pair and leaves the extension register alone. The unit works iteratively: it consumes one bit of the first operand per clock. It reports busy for the whole run and pulses done in the cycle the result pair changes. Reduction modulo a field polynomial is left to the surrounding logic.

Top module: `clmul_acc_unit`

## Requirements
- R1: While reset is held, and after it is released until a start is taken, busy_o, done_o and ext_clr_o are 0 and hi_o and lo_o are all zeros.
- R2: A start_i seen while busy_o is 0 is accepted, and busy_o is 1 in the following cycle.
- R3: After an accepted start, busy_o stays 1 for exactly 32 cycles. In the next cycle busy_o is 0 and done_o is 1 for that single cycle.
- R4: With accum_i = 0 (multiply), lo_o takes bits 31..0 and hi_o takes bits 63..32 of the carry-less product of opa_i and opb_i, captured at the start.
- R5: ext_clr_o is 1 for exactly the done cycle of a multiply-mode operation, and is 0 at all other times.
- R6: With accum_i = 1 (accumulate), lo_o becomes its old value XOR product bits 31..0 and hi_o becomes its old value XOR product bits 63..32. ext_clr_o stays 0.
- R7: Bit 63 of every product is zero, so hi_o bit 31 is 0 after any multiply-mode operation.
- R8: A start_i received while busy_o is 1 is ignored. The running operation keeps its operands, mode and timing.
- R9: hi_o and lo_o change only in the cycle done_o is 1.
- R10: A start_i in the done cycle is accepted as a fresh operation, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, taken when idle |
| accum_i | input | 1 | Mode: 0 = multiply, 1 = multiply-accumulate |
| opa_i | input | 32 | First polynomial operand |
| opb_i | input | 32 | Second polynomial operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result pair is updated |
| hi_o | output | 32 | High word of the result pair |
| lo_o | output | 32 | Low word of the result pair |
| ext_clr_o | output | 1 | Request to clear the extension register (multiply mode) |

## Verification
The operand pair 3 × 3 must give 5 and not 9, which tells carry-less from integer multiplication. All-ones operands exercise every partial product, since each one cancels or survives by parity. Two top-bit operands place the product on bit 62, checking the word split and the zero top bit. A zero operand checks that nothing leaks from the previous result. Accumulating the same product twice must bring the result pair back to its prior value, which tells XOR from add. A start raised during a run and a start raised in the done cycle separate the ignore rule from back-to-back acceptance.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  typedef enum logic {
    MODE_MUL = 1'b0,
    MODE_MAC = 1'b1
  } clmul_mode_e;
endpackage

// File: rtl/clmul_seq_ctrl.sv
module clmul_seq_ctrl
  import clmul_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  clmul_mode_e mode_i,
  output logic        busy_o,
  output logic        load_o,
  output logic        last_o,
  output logic        done_o,
  output clmul_mode_e mode_o
);
  localparam int CW = $clog2(OPW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  clmul_mode_e   mode_q, mode_d;

  assign load_o = start_i && !busy_q;
  assign last_o = busy_q && (cnt_q == CW'(OPW - 1));

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    mode_d = mode_q;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      mode_d = mode_i;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last_o) begin
        busy_d = 1'b0;
      end
    end
    done_d = last_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= MODE_MUL;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      mode_q <= mode_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/clmul_shift_dp.sv
module clmul_shift_dp #(
  parameter int OPW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [OPW-1:0]  opa_i,
  input  logic [OPW-1:0]  opb_i,
  output logic [2*OPW-1:0] prod_nx_o
);
  localparam int PW = 2 * OPW;

  logic [OPW-1:0] mplr_q, mplr_d;
  logic [PW-1:0]  mcnd_q, mcnd_d;
  logic [PW-1:0]  part_q, part_d;
  logic [PW-1:0]  term;
  logic           en;

  // Partial product for this step: the shifted multiplicand, gated by the current multiplier bit
  assign term      = mplr_q[0] ? mcnd_q : '0;
  assign prod_nx_o = part_q ^ term;
  assign en        = load_i || step_i;

  always_comb begin
    if (load_i) begin
      mplr_d = opa_i;
      mcnd_d = {{OPW{1'b0}}, opb_i};
      part_d = '0;
    end else begin
      mplr_d = mplr_q >> 1;
      mcnd_d = mcnd_q << 1;
      part_d = prod_nx_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mplr_q <= '0;
      mcnd_q <= '0;
      part_q <= '0;
    end else if (en) begin
      mplr_q <= mplr_d;
      mcnd_q <= mcnd_d;
      part_q <= part_d;
    end
  end
endmodule

// File: rtl/clmul_hilo_regs.sv
module clmul_hilo_regs
  import clmul_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  clmul_mode_e      mode_i,
  input  logic [2*OPW-1:0] prod_i,
  output logic [OPW-1:0]   hi_o,
  output logic [OPW-1:0]   lo_o,
  output logic             ext_clr_o
);
  logic [OPW-1:0] hi_q, hi_d, lo_q, lo_d;
  logic           xclr_q, xclr_d;

  always_comb begin
    if (mode_i == MODE_MAC) begin
      hi_d = hi_q ^ prod_i[2*OPW-1:OPW];
      lo_d = lo_q ^ prod_i[OPW-1:0];
    end else begin
      hi_d = prod_i[2*OPW-1:OPW];
      lo_d = prod_i[OPW-1:0];
    end
    xclr_d = commit_i && (mode_i == MODE_MUL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (commit_i) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xclr_q <= 1'b0;
    end else begin
      xclr_q <= xclr_d;
    end
  end

  assign hi_o      = hi_q;
  assign lo_o      = lo_q;
  assign ext_clr_o = xclr_q;
endmodule

// File: rtl/clmul_acc_unit.sv
module clmul_acc_unit
  import clmul_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           accum_i,
  input  logic [OPW-1:0] opa_i,
  input  logic [OPW-1:0] opb_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [OPW-1:0] hi_o,
  output logic [OPW-1:0] lo_o,
  output logic           ext_clr_o
);
  localparam int PW = 2 * OPW;

  logic          rst_meta_n, rst_sync_n;
  logic          load, last;
  clmul_mode_e   run_mode;
  logic [PW-1:0] prod_nx;

  // Reset asserts at once and releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  clmul_seq_ctrl #(.OPW(OPW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .mode_i  (clmul_mode_e'(accum_i)),
    .busy_o  (busy_o),
    .load_o  (load),
    .last_o  (last),
    .done_o  (done_o),
    .mode_o  (run_mode)
  );

  clmul_shift_dp #(.OPW(OPW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (load),
    .step_i    (busy_o),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .prod_nx_o (prod_nx)
  );

  clmul_hilo_regs #(.OPW(OPW)) u_hilo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .commit_i  (last),
    .mode_i    (run_mode),
    .prod_i    (prod_nx),
    .hi_o      (hi_o),
    .lo_o      (lo_o),
    .ext_clr_o (ext_clr_o)
  );
endmodule

// File: rtl/clmul_acc_unit_chk.sv
module clmul_acc_unit_chk #(
  parameter int OPW = 32
) (
  input logic           clk,
  input logic           rst_q_n,
  input logic           start_i,
  input logic           accum_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [OPW-1:0] hi_o,
  input logic [OPW-1:0] lo_o,
  input logic           ext_clr_o
);
  localparam int RW = $clog2(OPW) + 1;

  logic [RW-1:0] run_cnt;
  logic          mac_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      run_cnt <= '0;
      mac_q   <= 1'b0;
    end else begin
      run_cnt <= busy_o ? run_cnt + 1'b1 : '0;
      if (start_i && !busy_o) begin
        mac_q <= accum_i;
      end
    end
  end

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |=> !done_o); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |-> (run_cnt == RW'(OPW))); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |-> !busy_o); // R3
  AST_CLR_IN_DONE: assert property (@(posedge clk) disable iff (!rst_q_n)
    ext_clr_o |-> done_o); // R5
  AST_CLR_ON_MUL: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done_o && !mac_q) |-> ext_clr_o); // R5
  AST_NO_CLR_ON_MAC: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done_o && mac_q) |-> !ext_clr_o); // R6
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    ext_clr_o |-> !hi_o[OPW-1]); // R7
  AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !done_o |-> ($stable(hi_o) && $stable(lo_o))); // R9
endmodule

bind clmul_acc_unit clmul_acc_unit_chk #(.OPW(OPW)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .start_i   (start_i),
  .accum_i   (accum_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .hi_o      (hi_o),
  .lo_o      (lo_o),
  .ext_clr_o (ext_clr_o)
);

// File: tb/test_clmul_acc_unit.sv
`timescale 1ns/1ps
module test_clmul_acc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        accum_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        busy_o, done_o, ext_clr_o;
  logic [31:0] hi_o, lo_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  clmul_acc_unit i_clmul_acc_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .accum_i(accum_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .hi_o(hi_o), .lo_o(lo_o), .ext_clr_o(ext_clr_o)
  );

  function automatic logic [63:0] ref_clmul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      if (b[i]) r = r ^ ({32'h0, a} << i);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  bit          m_busy, m_done, m_ext, m_acc;
  int          m_left;
  logic [31:0] m_hi, m_lo, m_a, m_b;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_ext <= 0; m_hi <= '0; m_lo <= '0; m_left <= 0; m_acc <= 0;
    end else begin
      m_done <= 0;
      m_ext  <= 0;
      if (!m_busy && start_i) begin
        m_busy <= 1; m_left <= 32; m_a <= opa_i; m_b <= opb_i; m_acc <= accum_i;
      end else if (m_busy) begin
        m_left <= m_left - 1;
        if (m_left == 1) begin
          logic [63:0] p;
          p = ref_clmul(m_a, m_b);
          m_busy <= 0;
          m_done <= 1;
          if (m_acc) begin
            m_hi <= m_hi ^ p[63:32]; m_lo <= m_lo ^ p[31:0];
          end else begin
            m_hi <= p[63:32]; m_lo <= p[31:0]; m_ext <= 1;
          end
        end
      end
    end
  end

  // Cycle compare; the R9 hold rule is covered by hi/lo matching every cycle
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(busy_o === m_busy, "R3 busy", busy_o, m_busy);
      chk(done_o === m_done, "R3 done", done_o, m_done);
      chk(ext_clr_o === m_ext, "R5 ext_clr", ext_clr_o, m_ext);
      chk(hi_o === m_hi, m_acc ? "R6 hi" : "R4 hi", hi_o, m_hi);
      chk(lo_o === m_lo, m_acc ? "R6 lo" : "R4 lo", lo_o, m_lo);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // Called at a falling edge; returns at the falling edge that shows done
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit acc, output int lat);
    start_i = 1; accum_i = acc; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 0;
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [31:0] sh, sl;
    logic [63:0] p;
    repeat (3) @(negedge clk);
    chk(busy_o === 0 && done_o === 0 && ext_clr_o === 0, "R1 ctrl in reset", {busy_o, done_o, ext_clr_o}, 0);
    chk(hi_o === 0 && lo_o === 0, "R1 hilo in reset", {hi_o, lo_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_en = 1;
    chk(busy_o === 0 && hi_o === 0 && lo_o === 0, "R1 idle after release", {busy_o, hi_o}, 0);

    run_op(32'h3, 32'h3, 0, lat);
    chk(lat == 33, "R3 latency", lat, 33);
    chk(lo_o === 32'h5 && hi_o === 0, "R4 3x3 carry-less", {hi_o, lo_o}, 64'h5);

    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, lat);
    p = ref_clmul(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk({hi_o, lo_o} === p, "R4 all ones", {hi_o, lo_o}, p);

    run_op(32'h8000_0000, 32'h8000_0000, 0, lat);
    chk(hi_o === 32'h4000_0000 && lo_o === 0, "R4 top bits", {hi_o, lo_o}, 64'h4000_0000_0000_0000);
    chk(hi_o[31] === 1'b0, "R7 bit 63 zero", hi_o[31], 0);

    run_op(32'h0, 32'h1234_5678, 0, lat);
    chk(hi_o === 0 && lo_o === 0, "R4 zero operand", {hi_o, lo_o}, 0);

    run_op(32'hDEAD_BEEF, 32'h1234_ABCD, 0, lat);
    sh = hi_o; sl = lo_o;
    chk(ext_clr_o === 1, "R5 clear on multiply", ext_clr_o, 1);
    run_op(32'h0F0F_00FF, 32'h8001_7003, 1, lat);
    p = ref_clmul(32'h0F0F_00FF, 32'h8001_7003) ^ {sh, sl};
    chk({hi_o, lo_o} === p, "R6 accumulate xor", {hi_o, lo_o}, p);
    chk(ext_clr_o === 0, "R6 no clear", ext_clr_o, 0);
    run_op(32'h0F0F_00FF, 32'h8001_7003, 1, lat);
    chk({hi_o, lo_o} === {sh, sl}, "R6 double accumulate cancels", {hi_o, lo_o}, {sh, sl});

    // R8: a second start mid-run must change nothing
    start_i = 1; accum_i = 0; opa_i = 32'h5; opb_i = 32'h6;
    @(negedge clk);
    start_i = 0;
    repeat (4) @(negedge clk);
    start_i = 1; accum_i = 1; opa_i = 32'hFFFF; opb_i = 32'hFFFF;
    @(negedge clk);
    start_i = 0;
    lat = 6;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 33, "R8 timing kept", lat, 33);
    chk(hi_o === 0 && lo_o === 32'h1E, "R8 operands kept", {hi_o, lo_o}, 64'h1E);
    chk(ext_clr_o === 1, "R8 mode kept", ext_clr_o, 1);

    // R10: start in the done cycle
    start_i = 1; accum_i = 0; opa_i = 32'h7; opb_i = 32'h9;
    @(negedge clk);
    start_i = 0;
    chk(busy_o === 1, "R10 back-to-back accepted", busy_o, 1);
    chk(busy_o === 1, "R2 busy after start", busy_o, 1);
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lo_o === 32'h3F && hi_o === 0, "R10 result", {hi_o, lo_o}, 64'h3F);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule